// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block is a ring counter that moves a single active bit, one position per clock, from the lowest stage toward the highest. The last stage is not wrapped back into the first. Instead, the bit entering stage 0 is worked out from the stages below the top one. A new active bit enters only when none of those lower stages holds one. Because of this, any pattern in the register, including a corrupted or never-initialised one, falls back into the one-hot cycle within a few enabled clocks. A synchronous clear gives a known start, and no explicit seeding load is needed.

The register is built as a universal-style shift register. A small priority decoder turns clear, parallel load and enable into one of four modes: clear, load, shift or hold. Each stage is a mode-driven flop. The parallel load is part of the shift-register fabric. It lets a user place any pattern in the register, and the self-correction then brings that pattern into the cycle. A parameter selects the inverted variant, in which a single zero travels through a field of ones and clear presets the first legal pattern directly.

Top module: `selfcorr_ring_counter`

## Requirements
- R1: With `clr` high at a rising clock edge, `q` becomes the clear pattern on that edge, whatever `load` and `en` are. The clear pattern is 4'b0000 in the normal variant and 4'b1110 in the inverted variant (q[3] on the left).
- R2: With `clr` low and `load` high, `q` takes `load_val` on the edge, whether `en` is high or low.
- R3: With `clr`, `load` and `en` all low, `q` keeps its value.
- R4: With only `en` high, each stage q[i] for i>0 takes the old q[i-1] on the edge.
- R5: In the normal variant, on a shift the new q[0] is 1 exactly when the old q[0], q[1] and q[2] are all 0, so 0000 steps to 0001.
- R6: In the normal variant the legal cycle is 0001, 0010, 0100, 1000 and back to 0001, and a legal state stays legal across shifts.
- R7: From any of the 16 possible states, at most 4 enabled clocks bring the counter to a legal (single active bit) state.
- R8: In the inverted variant, on a shift the new q[0] is 0 exactly when the old q[0], q[1] and q[2] are all 1. The cycle is 1110, 1101, 1011, 0111 and back to 1110, and any state converges within 4 enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to the variant's clear pattern; highest priority |
| en | input | 1 | Shift enable; state holds when low |
| load | input | 1 | Synchronous parallel load of `load_val` |
| load_val | input | WIDTH | Pattern written by `load` |
| q | output | WIDTH | Stage outputs, q[0] first stage, q[WIDTH-1] last |

## Verification
The bench places every one of the 16 patterns in the register and follows each one clock by clock until it is legal. A design that fed back only the top bit, or only some of the lower stages, would keep several active bits circulating or stall at all zeros, and that run would fail. It also starts the legal sequence from 0000 with no load, which catches a feedback that never inserts the first bit. It checks that clear beats load and enable and that load works while the counter is disabled; a priority slip there would leave the wrong pattern in `q`. The inverted instance goes through the same sweep, so a polarity mistake in its feedback or its preset shows up as a wrong state.

// File: rtl/selfcorr_ring_pkg.sv
package selfcorr_ring_pkg;

   // Operating mode of every stage for one clock; priority is resolved
   // before this type is formed.
   typedef enum logic [1:0] {
      RING_HOLD  = 2'd0,
      RING_SHIFT = 2'd1,
      RING_LOAD  = 2'd2,
      RING_CLEAR = 2'd3
   } ring_mode_e;

   // Smallest supported register length: the feedback needs at least one
   // stage below the top one.
   localparam int unsigned RING_MIN_WIDTH = 2;

endpackage

// File: rtl/ring_mode_ctrl.sv
module ring_mode_ctrl
   import selfcorr_ring_pkg::*;
(
   input  logic       clr,
   input  logic       load,
   input  logic       en,
   output ring_mode_e mode
);

   // Fixed priority: clear, then load, then shift, else hold.
   always_comb begin
      if (clr)       mode = RING_CLEAR;
      else if (load) mode = RING_LOAD;
      else if (en)   mode = RING_SHIFT;
      else           mode = RING_HOLD;
   end

endmodule

// File: rtl/ring_feedback.sv
module ring_feedback #(
   parameter int unsigned WIDTH    = 4,
   parameter bit          INVERTED = 1'b0
) (
   input  logic [WIDTH-1:0] q,
   output logic             serial_in
);

   localparam int unsigned LOW_BITS = WIDTH - 1;

   logic [LOW_BITS-1:0] low_stages;
   assign low_stages = q[LOW_BITS-1:0];

   generate
      if (INVERTED) begin : g_zero_token
         // Insert a zero only when no zero is left below the top stage.
         assign serial_in = ~(&low_stages);
      end else begin : g_one_token
         // Insert a one only when no one is left below the top stage.
         assign serial_in = ~(|low_stages);
      end
   endgenerate

endmodule

// File: rtl/ring_stage.sv
module ring_stage
   import selfcorr_ring_pkg::*;
#(
   parameter bit CLR_VALUE = 1'b0
) (
   input  logic       clk,
   input  ring_mode_e mode,
   input  logic       shift_in,
   input  logic       load_bit,
   output logic       q
);

   always_ff @(posedge clk) begin
      unique case (mode)
         RING_CLEAR: q <= CLR_VALUE;
         RING_LOAD:  q <= load_bit;
         RING_SHIFT: q <= shift_in;
         default:    q <= q;
      endcase
   end

endmodule

// File: rtl/selfcorr_ring_counter.sv
module selfcorr_ring_counter
   import selfcorr_ring_pkg::*;
#(
   parameter int unsigned WIDTH    = 4,
   parameter bit          INVERTED = 1'b0
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] FIRST_ONE = {{(WIDTH-1){1'b0}}, 1'b1};
   // Normal: all zero, feedback inserts the token. Inverted: first legal state.
   localparam logic [WIDTH-1:0] CLR_PAT   = INVERTED ? ~FIRST_ONE : '0;

   generate
      if (WIDTH < RING_MIN_WIDTH) begin : g_bad_width
         $error("selfcorr_ring_counter: WIDTH must be at least 2");
      end
   endgenerate

   ring_mode_e mode;
   logic       fb_bit;
   logic [WIDTH-1:0] shift_src;

   ring_mode_ctrl u_mode (
      .clr  (clr),
      .load (load),
      .en   (en),
      .mode (mode)
   );

   ring_feedback #(
      .WIDTH    (WIDTH),
      .INVERTED (INVERTED)
   ) u_fb (
      .q         (q),
      .serial_in (fb_bit)
   );

   assign shift_src = {q[WIDTH-2:0], fb_bit};

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         ring_stage #(
            .CLR_VALUE (CLR_PAT[i])
         ) u_stage (
            .clk      (clk),
            .mode     (mode),
            .shift_in (shift_src[i]),
            .load_bit (load_val[i]),
            .q        (q[i])
         );
      end
   endgenerate

endmodule

// File: rtl/selfcorr_ring_counter_chk.sv
module selfcorr_ring_counter_chk #(
   parameter int unsigned WIDTH    = 4,
   parameter bit          INVERTED = 1'b0
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic [WIDTH-1:0] q
);

   localparam logic [WIDTH-1:0] FIRST_ONE = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] CLR_PAT   = INVERTED ? ~FIRST_ONE : '0;
   localparam int unsigned      CW        = $clog2(WIDTH + 1);

   logic          armed_q = 1'b0;
   logic [CW-1:0] run_q   = '0;
   logic          legal;

   // Token view is polarity-independent: a single active bit.
   assign legal = INVERTED ? $onehot(~q) : $onehot(q);

   always_ff @(posedge clk) begin
      armed_q <= armed_q | clr;
      if (clr || load)                 run_q <= '0;
      else if (en && (int'(run_q) < WIDTH)) run_q <= run_q + 1'b1;
   end

   // R1
   clear_pattern_chk: assert property (@(posedge clk) disable iff (!armed_q)
      clr |=> (q == CLR_PAT));

   // R2
   load_takes_chk: assert property (@(posedge clk) disable iff (clr || !armed_q)
      load |=> (q == $past(load_val)));

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (clr || !armed_q)
      (!load && !en) |=> $stable(q));

   // R4
   shift_move_chk: assert property (@(posedge clk) disable iff (clr || !armed_q)
      (!load && en) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

   // R6
   legal_kept_chk: assert property (@(posedge clk) disable iff (clr || !armed_q)
      (legal && !load && en) |=> legal);

   // R7
   converge_bound_chk: assert property (@(posedge clk) disable iff (clr || !armed_q)
      (int'(run_q) == WIDTH) |-> legal);

endmodule

bind selfcorr_ring_counter selfcorr_ring_counter_chk #(
   .WIDTH    (WIDTH),
   .INVERTED (INVERTED)
) chk_i (
   .clk      (clk),
   .clr      (clr),
   .en       (en),
   .load     (load),
   .load_val (load_val),
   .q        (q)
);

// File: tb/selfcorr_ring_counter_tb_top.sv
module selfcorr_ring_counter_tb_top;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         clr = 1'b0, en = 1'b0, load = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] q_n, q_i;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   selfcorr_ring_counter #(.WIDTH(W), .INVERTED(1'b0)) dut_i (
      .clk(clk), .clr(clr), .en(en), .load(load), .load_val(load_val), .q(q_n));

   selfcorr_ring_counter #(.WIDTH(W), .INVERTED(1'b1)) dut_inv_i (
      .clk(clk), .clr(clr), .en(en), .load(load), .load_val(load_val), .q(q_i));

   // Expected next state on a shift, from the requirement text.
   function automatic logic [W-1:0] nxt_norm(logic [W-1:0] s);
      return {s[W-2:0], (s[2:0] == 3'b000)};
   endfunction
   function automatic logic [W-1:0] nxt_inv(logic [W-1:0] s);
      return {s[W-2:0], (s[2:0] != 3'b111)};
   endfunction
   function automatic bit one_active(logic [W-1:0] s);
      return ($countones(s) == 1);
   endfunction

   task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // Advance one edge; inputs change and outputs are read 1 ns after it.
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(bit c, bit l, bit e, logic [W-1:0] v);
      clr = c; load = l; en = e; load_val = v;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%b expected=%b", 1'b0, 1'b1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] en_n, en_i;
      #2;
      // R1: clear state of both variants
      drive(1, 0, 0, '0); tick();
      chk(q_n == 4'b0000, "R1 clear normal", q_n, 4'b0000);
      chk(q_i == 4'b1110, "R1 clear inverted", q_i, 4'b1110);

      // R5 / R6: start from 0000 with no load, three full cycles
      en_n = 4'b0000; en_i = 4'b1110;
      drive(0, 0, 1, '0);
      for (int k = 0; k < 12; k++) begin
         tick();
         en_n = nxt_norm(en_n); en_i = nxt_inv(en_i);
         chk(q_n == en_n, "R5 R6 legal sequence normal", q_n, en_n);
         chk(q_n == (4'b0001 << (k % 4)), "R6 position normal", q_n, 4'b0001 << (k % 4));
         chk(q_i == en_i, "R8 legal sequence inverted", q_i, en_i);
         chk(q_i == ~(4'b0001 << ((k + 1) % 4)), "R8 position inverted", q_i, ~(4'b0001 << ((k + 1) % 4)));
      end

      // R3: enable low holds both counters
      en_n = q_n; en_i = q_i;
      drive(0, 0, 0, 4'b1010);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk(q_n == en_n, "R3 hold normal", q_n, en_n);
         chk(q_i == en_i, "R3 hold inverted", q_i, en_i);
      end

      // R2: load while disabled
      drive(0, 1, 0, 4'b1011); tick();
      chk(q_n == 4'b1011, "R2 load with en low", q_n, 4'b1011);
      // R1: clear beats load and enable
      drive(1, 1, 1, 4'b0110); tick();
      chk(q_n == 4'b0000, "R1 clear priority normal", q_n, 4'b0000);
      chk(q_i == 4'b1110, "R1 clear priority inverted", q_i, 4'b1110);

      // R7 / R8 / R4: sweep all 16 seeds, follow each clock
      for (int s = 0; s < 16; s++) begin
         drive(0, 1, 1, 4'(s)); tick();
         chk(q_n == 4'(s), "R2 seed load normal", q_n, 4'(s));
         chk(q_i == 4'(s), "R2 seed load inverted", q_i, 4'(s));
         en_n = 4'(s); en_i = 4'(s);
         drive(0, 0, 1, '0);
         for (int k = 0; k < 4; k++) begin
            tick();
            en_n = nxt_norm(en_n); en_i = nxt_inv(en_i);
            chk(q_n[3:1] == en_n[3:1], "R4 shift normal", q_n, en_n);
            chk(q_n == en_n, "R5 feedback normal", q_n, en_n);
            chk(q_i == en_i, "R8 feedback inverted", q_i, en_i);
         end
         chk(one_active(q_n), "R7 converged normal", q_n, en_n);
         chk(one_active(~q_i), "R8 converged inverted", q_i, en_i);
      end

      drive(0, 0, 0, '0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule